// File: doc/BRIEF.md
# Write-Back Cache Miss Controller

This block is the control path of a set-associative write-back cache that sits between a 32-bit processor and a memory port that moves one 32-bit word per clock. It splits the processor byte address into tag, set index and word offset. The selected set reports whether the request tag hits and which victim line it would replace, giving that line's valid bit, dirty bit and stored tag. From these the controller decides between completing the access at once and running a miss sequence. The tag and data arrays are outside the block.

On a miss the controller stalls the processor. If the victim is both valid and dirty, it first streams the victim block out to memory, one word per cycle. It then refills the block from memory one word per cycle, writing each word into the line. After the last refill word it goes back to idle, and the access completes there as a hit. Two machines work together: an action machine (idle, write-back, refill) and a word-offset counter. The action machine leaves each burst phase only when the counter shows the final word. The replacement logic receives one update pulse per access, in the cycle the access completes.

Top module: `wb_miss_ctrl`

## Requirements
- R1: `tag_o` is address bits [31:S_W+B_W], `set_o` is bits [S_W+B_W-1:B_W], and `word_o` is bits [B_W-1:2], where word k of a block is at byte offset 4k.
- R2: A load that hits in idle completes in the same cycle: `stall_o`=0, `repl_en_o`=1, `line_we_o`=0, and both memory strobes are 0.
- R3: A store that hits in idle writes one word in the same cycle with no memory traffic: `line_we_o`=1, `src_mem_o`=0, `line_word_o`=`word_o`, `line_valid_o`=1, `line_dirty_o`=1, `line_tag_o`=`tag_o`, `stall_o`=0.
- R4: The first cycle of a miss (idle, request, no hit) asserts `stall_o` and asserts no memory strobe, no line write and no replacement enable.
- R5: When the victim is valid and dirty, the next 2^(B_W-2) cycles each assert `mem_wr_o` only, with `mem_addr_o` = {victim tag, set, k, 2'b00} and `line_word_o`=k, for k rising from 0, and with no line write.
- R6: The cycle after the last write-back word is the first refill word. There is no idle gap between the two phases.
- R7: Each refill cycle asserts `mem_rd_o`, `line_we_o` and `src_mem_o`, with `mem_addr_o` = {request tag, set, k, 2'b00} and `line_word_o`=k, for k rising from 0 to 2^(B_W-2)-1.
- R8: Refill words before the last are written with valid=0, dirty=0 and the request tag. The last refill word is written with valid=1 and dirty equal to the store flag.
- R9: `stall_o` stays 1 in every cycle of a miss. After the last refill word the controller returns to idle, and the access completes there as a hit.
- R10: `repl_en_o` is 1 exactly once per access, only in the cycle where `stall_o` is 0.
- R11: A victim that is not valid, or valid but clean, skips write-back, and refill starts in the cycle after the first miss cycle.
- R12: After reset, with no request, `stall_o`, both memory strobes, `line_we_o` and `repl_en_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Processor access valid |
| we_i | input | 1 | Access is a store |
| addr_i | input | 32 | Processor byte address |
| hit_i | input | 1 | Selected set holds a valid line with the request tag |
| vic_valid_i | input | 1 | Victim line valid |
| vic_dirty_i | input | 1 | Victim line dirty |
| vic_tag_i | input | T_W | Victim line stored tag |
| tag_o | output | T_W | Request tag field |
| set_o | output | S_W | Request set index |
| word_o | output | B_W-2 | Request word offset |
| stall_o | output | 1 | Hold the processor |
| mem_rd_o | output | 1 | Memory word read strobe |
| mem_wr_o | output | 1 | Memory word write strobe |
| mem_addr_o | output | 32 | Memory word byte address |
| line_we_o | output | 1 | Line write enable (data and metadata) |
| line_word_o | output | B_W-2 | Word of the line being read or written |
| src_mem_o | output | 1 | Line write data from memory (1) or processor (0) |
| line_valid_o | output | 1 | Valid bit to write |
| line_dirty_o | output | 1 | Dirty bit to write |
| line_tag_o | output | T_W | Tag to write |
| repl_en_o | output | 1 | Replacement state update pulse |

## Verification
Two things happen in the last refill cycle: the final memory word is stored, and the line's metadata turns valid, carrying the store-dependent dirty bit. Both are driven by the same counter value. Store and load misses on dirty and clean victims, at random sets and tags, provoke this case many times. Each cycle is judged against an expected per-word table: only the final word may carry valid=1, and its dirty bit must equal the store flag, while the write-back strobe for that block must already have ended.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WBACK  = 2'd1,
    ST_REFILL = 2'd2
  } wbc_state_e;
endpackage

// File: rtl/wbc_addr_split.sv
module wbc_addr_split #(
  parameter int S_W = 2,
  parameter int B_W = 4,
  localparam int T_W = 32 - S_W - B_W,
  localparam int OW_W = B_W - 2
) (
  input  logic [31:0]      addr_i,
  output logic [T_W-1:0]   tag_o,
  output logic [S_W-1:0]   set_o,
  output logic [OW_W-1:0]  word_o
);
  assign tag_o  = addr_i[31 -: T_W];
  assign set_o  = addr_i[B_W +: S_W];
  assign word_o = addr_i[2 +: OW_W];
endmodule

// File: rtl/wbc_ofs_cnt.sv
module wbc_ofs_cnt #(
  parameter int OW_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  output logic [OW_W-1:0] cnt_o,
  output logic            last_o
);
  logic [OW_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_q + 1'b1;  // wraps to 0 after the last word
  end

  assign cnt_o  = cnt_q;
  assign last_o = &cnt_q;

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_o));  // R5
endmodule

// File: rtl/wbc_action_fsm.sv
module wbc_action_fsm
  import wbc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       we_i,
  input  logic       hit_i,
  input  logic       vic_valid_i,
  input  logic       vic_dirty_i,
  input  logic       last_i,
  output wbc_state_e state_o,
  output logic       cnt_en_o,
  output logic       stall_o,
  output logic       mem_rd_o,
  output logic       mem_wr_o,
  output logic       line_we_o,
  output logic       src_mem_o,
  output logic       line_valid_o,
  output logic       line_dirty_o,
  output logic       use_vic_tag_o,
  output logic       repl_en_o
);
  wbc_state_e state_q, state_d;
  logic       need_wb;

  assign need_wb = vic_valid_i & vic_dirty_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_i && !hit_i) state_d = need_wb ? ST_WBACK : ST_REFILL;
      ST_WBACK:  if (last_i) state_d = ST_REFILL;
      ST_REFILL: if (last_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    cnt_en_o      = 1'b0;
    stall_o       = 1'b0;
    mem_rd_o      = 1'b0;
    mem_wr_o      = 1'b0;
    line_we_o     = 1'b0;
    src_mem_o     = 1'b0;
    line_valid_o  = 1'b0;
    line_dirty_o  = 1'b0;
    use_vic_tag_o = 1'b0;
    repl_en_o     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i && hit_i) begin
          repl_en_o    = 1'b1;
          line_we_o    = we_i;
          line_valid_o = 1'b1;
          line_dirty_o = 1'b1;
        end else if (req_i) begin
          stall_o = 1'b1;
        end
      end
      ST_WBACK: begin
        stall_o       = 1'b1;
        cnt_en_o      = 1'b1;
        mem_wr_o      = 1'b1;
        use_vic_tag_o = 1'b1;
      end
      ST_REFILL: begin
        stall_o      = 1'b1;
        cnt_en_o     = 1'b1;
        mem_rd_o     = 1'b1;
        line_we_o    = 1'b1;
        src_mem_o    = 1'b1;
        // metadata becomes live only with the final word
        line_valid_o = last_i;
        line_dirty_o = last_i & we_i;
      end
      default: ;
    endcase
  end

  assign state_o = state_q;

  AST_WB_HANDOVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WBACK && last_i) |=> (state_q == ST_REFILL));  // R6
  AST_WB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WBACK && !last_i) |=> (state_q == ST_WBACK));  // R5
  AST_REFILL_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REFILL && last_i) |=> (state_q == ST_IDLE));  // R9
  AST_CLEAN_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && req_i && !hit_i && !need_wb) |=> (state_q == ST_REFILL));  // R11
endmodule

// File: rtl/wb_miss_ctrl.sv
module wb_miss_ctrl
  import wbc_pkg::*;
#(
  parameter int S_W = 2,
  parameter int B_W = 4,
  localparam int T_W = 32 - S_W - B_W,
  localparam int OW_W = B_W - 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [31:0]     addr_i,
  input  logic            hit_i,
  input  logic            vic_valid_i,
  input  logic            vic_dirty_i,
  input  logic [T_W-1:0]  vic_tag_i,
  output logic [T_W-1:0]  tag_o,
  output logic [S_W-1:0]  set_o,
  output logic [OW_W-1:0] word_o,
  output logic            stall_o,
  output logic            mem_rd_o,
  output logic            mem_wr_o,
  output logic [31:0]     mem_addr_o,
  output logic            line_we_o,
  output logic [OW_W-1:0] line_word_o,
  output logic            src_mem_o,
  output logic            line_valid_o,
  output logic            line_dirty_o,
  output logic [T_W-1:0]  line_tag_o,
  output logic            repl_en_o
);
  wbc_state_e      state;
  logic [OW_W-1:0] cnt;
  logic            last, cnt_en, use_vic_tag;

  wbc_addr_split #(.S_W(S_W), .B_W(B_W)) u_split (
    .addr_i (addr_i),
    .tag_o  (tag_o),
    .set_o  (set_o),
    .word_o (word_o)
  );

  wbc_ofs_cnt #(.OW_W(OW_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cnt_en),
    .cnt_o  (cnt),
    .last_o (last)
  );

  wbc_action_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_i         (req_i),
    .we_i          (we_i),
    .hit_i         (hit_i),
    .vic_valid_i   (vic_valid_i),
    .vic_dirty_i   (vic_dirty_i),
    .last_i        (last),
    .state_o       (state),
    .cnt_en_o      (cnt_en),
    .stall_o       (stall_o),
    .mem_rd_o      (mem_rd_o),
    .mem_wr_o      (mem_wr_o),
    .line_we_o     (line_we_o),
    .src_mem_o     (src_mem_o),
    .line_valid_o  (line_valid_o),
    .line_dirty_o  (line_dirty_o),
    .use_vic_tag_o (use_vic_tag),
    .repl_en_o     (repl_en_o)
  );

  assign mem_addr_o  = {(use_vic_tag ? vic_tag_i : tag_o), set_o, cnt, 2'b00};
  assign line_word_o = (state == ST_IDLE) ? word_o : cnt;
  assign line_tag_o  = tag_o;

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));  // R7
  AST_MEM_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) |-> stall_o);  // R9
  AST_REPL_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    repl_en_o |-> !stall_o);  // R10
  AST_IDLE_CNT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> (cnt == '0));  // R5
  AST_FINAL_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_mem_o && line_valid_o) |-> last);  // R8
endmodule

// File: tb/wb_miss_ctrl_test.sv
module wb_miss_ctrl_test;
  localparam int S_W = 2;
  localparam int B_W = 4;
  localparam int T_W = 32 - S_W - B_W;
  localparam int OW_W = B_W - 2;
  localparam int NW = 1 << OW_W;

  logic clk = 0, rst_ni = 0;
  logic req = 0, we = 0, hit = 0, vv = 0, vd = 0;
  logic [31:0] addr = '0;
  logic [T_W-1:0] vtag = '0;
  logic [T_W-1:0] tag_o, line_tag_o;
  logic [S_W-1:0] set_o;
  logic [OW_W-1:0] word_o, line_word_o;
  logic stall_o, mem_rd_o, mem_wr_o, line_we_o, src_mem_o;
  logic line_valid_o, line_dirty_o, repl_en_o;
  logic [31:0] mem_addr_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wb_miss_ctrl #(.S_W(S_W), .B_W(B_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .hit_i(hit), .vic_valid_i(vv), .vic_dirty_i(vd), .vic_tag_i(vtag),
    .tag_o(tag_o), .set_o(set_o), .word_o(word_o), .stall_o(stall_o),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_addr_o(mem_addr_o),
    .line_we_o(line_we_o), .line_word_o(line_word_o), .src_mem_o(src_mem_o),
    .line_valid_o(line_valid_o), .line_dirty_o(line_dirty_o),
    .line_tag_o(line_tag_o), .repl_en_o(repl_en_o)
  );

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req_tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] waddr(input logic [T_W-1:0] t, input logic [S_W-1:0] s,
                                        input int k);
    logic [OW_W-1:0] kk = OW_W'(k);
    return {t, s, kk, 2'b00};
  endfunction

  task automatic chk_hit(input bit w, input logic [OW_W-1:0] wo, input logic [T_W-1:0] tg);
    chk("R10 repl", 32'(repl_en_o), 1);
    chk("R2 stall", 32'(stall_o), 0);
    chk("R2 mem", {30'd0, mem_rd_o, mem_wr_o}, 0);
    chk("R3 we", 32'(line_we_o), 32'(w));
    if (w) begin
      chk("R3 src", 32'(src_mem_o), 0);
      chk("R3 word", 32'(line_word_o), 32'(wo));
      chk("R3 meta", {30'd0, line_valid_o, line_dirty_o}, 32'b11);
      chk("R3 tag", 32'(line_tag_o), 32'(tg));
    end
  endtask

  task automatic access(input logic [T_W-1:0] tg, input logic [S_W-1:0] st,
                        input logic [OW_W-1:0] wo, input bit w, input bit is_hit,
                        input bit v_valid, input bit v_dirty, input logic [T_W-1:0] v_tag);
    req = 1; we = w; hit = is_hit; vv = v_valid; vd = v_dirty; vtag = v_tag;
    addr = {tg, st, wo, 2'($urandom)};
    #1;
    chk("R1 tag", 32'(tag_o), 32'(tg));
    chk("R1 set", 32'(set_o), 32'(st));
    chk("R1 word", 32'(word_o), 32'(wo));
    if (is_hit) begin
      chk_hit(w, wo, tg);
    end else begin
      chk("R4 stall", 32'(stall_o), 1);
      chk("R4 quiet", {29'd0, mem_rd_o, mem_wr_o, line_we_o}, 0);
      chk("R4 repl", 32'(repl_en_o), 0);
      @(negedge clk); #1;
      if (v_valid && v_dirty) begin
        for (int k = 0; k < NW; k++) begin
          chk("R5 wr", {30'd0, mem_wr_o, mem_rd_o}, 32'b10);
          chk("R5 addr", mem_addr_o, waddr(v_tag, st, k));
          chk("R5 word", 32'(line_word_o), 32'(k));
          chk("R5 nowe", 32'(line_we_o), 0);
          chk("R9 stall", 32'(stall_o), 1);
          chk("R10 repl", 32'(repl_en_o), 0);
          @(negedge clk); #1;
        end
      end
      for (int k = 0; k < NW; k++) begin
        chk(k == 0 ? "R6 R11 rd" : "R7 rd", {30'd0, mem_rd_o, mem_wr_o}, 32'b10);
        chk("R7 addr", mem_addr_o, waddr(tg, st, k));
        chk("R7 we", {30'd0, line_we_o, src_mem_o}, 32'b11);
        chk("R7 word", 32'(line_word_o), 32'(k));
        chk("R8 meta", {30'd0, line_valid_o, line_dirty_o},
            (k == NW - 1) ? {30'd0, 1'b1, w} : 32'd0);
        chk("R8 tag", 32'(line_tag_o), 32'(tg));
        chk("R9 stall", 32'(stall_o), 1);
        chk("R10 repl", 32'(repl_en_o), 0);
        if (k == NW - 1) hit = 1;
        @(negedge clk); #1;
      end
      chk_hit(w, wo, tg);  // R9 completes as hit
    end
    @(negedge clk);
    req = 0; hit = 0;
    #1;
    chk("R12 idle", {27'd0, stall_o, mem_rd_o, mem_wr_o, line_we_o, repl_en_o}, 0);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    #7 rst_ni = 1;
    @(negedge clk); #1;
    chk("R12 reset", {27'd0, stall_o, mem_rd_o, mem_wr_o, line_we_o, repl_en_o}, 0);
    @(negedge clk);
    // directed corners
    access('h1, 0, 0, 0, 1, 1, 1, 'h2);              // load hit
    access('h3, 3, 3, 1, 1, 0, 0, 'h0);              // store hit
    access('h5, 1, 2, 0, 0, 0, 1, 'h7);              // invalid victim, dirty ignored
    access('h9, 2, 1, 1, 0, 1, 0, 'hA);              // clean victim store miss
    access({T_W{1'b1}}, 3, 3, 1, 0, 1, 1, '0);       // dirty victim store miss
    access('0, 0, 0, 0, 0, 1, 1, {T_W{1'b1}});       // dirty victim load miss
    for (int i = 0; i < 60; i++)
      access(T_W'($urandom), S_W'($urandom), OW_W'($urandom), 1'($urandom),
             ($urandom % 3) == 0, 1'($urandom), 1'($urandom), T_W'($urandom));
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule